// File: doc/BRIEF.md
# Two-wire serial memory slave

This block is the target side of a two-wire serial memory bus. A faster system clock samples the clock and data lines, detects start and stop conditions, and decodes an 8-bit device word: the fixed prefix 1010, a three-bit select that must equal the strapped `dev_sel_i` input, and a direction bit. After the device word it takes a two-byte word address and then either collects data bytes for a write or sends bytes back for a read. Both sides exchange data in bytes of 8 bits, most significant bit first, and each byte is followed by a ninth clock for the acknowledge. The block pulls the data line low only through the open-drain enable `sda_oe_o`.

The block collects write data in a page buffer. It copies the buffer into a small internal byte array only after a clean stop. The copy runs inside a self-timed busy window that lasts `WR_CYCLES` system clocks. During that window the block ignores the bus completely, so a master can poll with device words until it gets an acknowledge. Current-address, random and sequential reads come from one address counter. While `wp_i` is high, no array location can change. Only the low `ADDR_W` bits of the word address are used, and a page holds `2**PAGE_W` bytes.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0. Outside an acknowledge or a 0 data bit that the block sends, `sda_oe_o` stays 0. After the master declines a read byte, the data line is released.
- R2: A device word is accepted only when its bits 7..4 are 1010 and its bits 3..1 equal `dev_sel_i`. The block then drives the ninth clock low. In any other case the block gives no acknowledge and ignores all further bytes until the next start.
- R3: For a write (bit 0 = 0), the block acknowledges the high word-address byte, the low word-address byte and each data byte. The address is {high, low}, and bits above `ADDR_W` are ignored. After a stop, a single data byte can be read back at that address.
- R4: In a page write, the low `PAGE_W` address bits advance after each data byte and wrap inside the page. Bytes beyond one page overwrite the earlier bytes at the same offsets.
- R5: A random read is a write that carries only the address, then a repeated start and a read device word (bit 0 = 1). It returns the byte at the loaded address.
- R6: The busy window starts with a stop that follows at least one data byte and lasts `WR_CYCLES` system clocks. Inside the window a device word gets no acknowledge. Once the window ends, a device word is acknowledged again.
- R7: When the master acknowledges a read byte, the block sends the byte at the next address. The address wraps from the last array location to 0.
- R8: A current-address read returns the byte one past the last accessed location. After a write, that location is the next offset in the same page, wrapping within the page.
- R9: While `wp_i` is 1, data bytes are still acknowledged, but the array does not change and no busy window starts.
- R10: A start or stop that arrives after two or more bits of a byte abandons the transfer. A repeated start after data bytes also discards them, and nothing is written. A device word right after such a start is acknowledged.
- R11: A write that ends with a stop after the address bytes alone starts no busy window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| dev_sel_i | input | 3 | Strapped device select compared with bits 3..1 of the device word |
| wp_i | input | 1 | Write protect, 1 blocks every array change |
| sda_oe_o | output | 1 | 1 pulls the data line low |

## Verification
Each bus line passes through two synchronizer flops and one edge-compare register, so the block reacts to a bus edge three system clocks after the edge. The bench master therefore holds every line for six clocks before its next move and samples the data line six clocks after each rising bus clock, well after any acknowledge or data bit has settled. The busy window is counted from the detected stop, and `WR_CYCLES` is 400. An immediate poll reaches its acknowledge bit about 250 clocks after the stop, which falls inside the window. A poll made 600 clocks later falls after it, so both sides of the window are tested with margin. The write-protect, abandoned-transfer and address-only cases use the same immediate poll to show that no window was started.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_BUSY
  } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop,
  output logic sda_lvl
);
  logic [STAGES-1:0] scl_sy;
  logic [STAGES-1:0] sda_sy;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;
  logic              sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[STAGES-2:0], sda_i};
      scl_q  <= scl_sy[STAGES-1];
      sda_q  <= sda_sy[STAGES-1];
    end
  end

  assign scl_s     = scl_sy[STAGES-1];
  assign sda_s     = sda_sy[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
  assign sda_lvl   = sda_s;
endmodule

// File: rtl/tw_byte_ram.sv
module tw_byte_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tw_wr_timer.sv
module tw_wr_timer #(
  parameter int LEN = 2000,
  parameter int CW  = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          busy,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == CW'(LEN - 1)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CW'(LEN)));

  // R6
  busy_ends_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cnt) == CW'(LEN - 1)));
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int PAGE     = 1 << PAGE_W;
  localparam int ROW_W    = ADDR_W - PAGE_W;
  localparam int HI_W     = ADDR_W - 8;
  localparam int BUSY_LEN = (WR_CYCLES > PAGE) ? WR_CYCLES : PAGE + 1;
  localparam int CNT_W    = $clog2(BUSY_LEN + 1);

  logic scl_rise, scl_fall, bus_start, bus_stop, sda_lvl;

  tw_line_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_lvl(sda_lvl)
  );

  tw_state_e          st;
  logic [3:0]         bitcnt;
  logic               ack_ph;
  logic               m_ack;
  logic [7:0]         sr;
  logic [7:0]         txsr;
  logic [HI_W-1:0]    addr_hi;
  logic [ADDR_W-1:0]  cur_addr;
  logic [ROW_W-1:0]   row;
  logic [PAGE_W-1:0]  woff;
  logic               have_data;
  logic [PAGE-1:0]    pval;
  logic [7:0]         pbuf [PAGE];
  logic               sda_oe_q;
  logic               tmr_go;
  logic               tmr_busy;
  logic [CNT_W-1:0]   tmr_cnt;
  logic [ADDR_W-1:0]  word_addr;
  logic               byte_done;
  logic               pbuf_we;
  logic [PAGE_W-1:0]  cidx;
  logic               mem_we;
  logic [7:0]         rdata;

  assign word_addr = {addr_hi, sr};
  assign byte_done = scl_fall && !ack_ph && (bitcnt == 4'd8);
  assign pbuf_we   = (st == ST_WDAT) && byte_done;
  assign cidx      = tmr_cnt[PAGE_W-1:0];
  assign mem_we    = tmr_busy && (tmr_cnt < CNT_W'(PAGE)) && pval[cidx];

  tw_wr_timer #(.LEN(BUSY_LEN), .CW(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .go(tmr_go), .busy(tmr_busy), .cnt(tmr_cnt)
  );

  tw_byte_ram #(.AW(ADDR_W)) ram_i (
    .clk(clk), .we(mem_we), .waddr({row, cidx}), .wdata(pbuf[cidx]),
    .raddr(cur_addr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (pbuf_we) pbuf[woff] <= sr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bitcnt    <= 4'd0;
      ack_ph    <= 1'b0;
      m_ack     <= 1'b0;
      sr        <= 8'd0;
      txsr      <= 8'd0;
      addr_hi   <= '0;
      cur_addr  <= '0;
      row       <= '0;
      woff      <= '0;
      have_data <= 1'b0;
      pval      <= '0;
      sda_oe_q  <= 1'b0;
      tmr_go    <= 1'b0;
    end else begin
      tmr_go <= 1'b0;
      if (st == ST_BUSY) begin
        if (!tmr_go && !tmr_busy) st <= ST_IDLE;
      end else if (bus_start) begin
        st       <= ST_DEV;
        bitcnt   <= 4'd0;
        ack_ph   <= 1'b0;
        sda_oe_q <= 1'b0;
      end else if (bus_stop) begin
        st       <= ST_IDLE;
        bitcnt   <= 4'd0;
        ack_ph   <= 1'b0;
        sda_oe_q <= 1'b0;
        if (st == ST_WDAT && have_data && !ack_ph && bitcnt <= 4'd1 && !wp_i) begin
          st     <= ST_BUSY;
          tmr_go <= 1'b1;
        end
      end else begin
        case (st)
          ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
            if (scl_rise && !ack_ph && bitcnt < 4'd8) begin
              sr     <= {sr[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              ack_ph   <= 1'b1;
              sda_oe_q <= 1'b1;
              case (st)
                ST_DEV: begin
                  if (sr[7:4] != 4'b1010 || sr[3:1] != dev_sel_i) begin
                    st       <= ST_IDLE;
                    ack_ph   <= 1'b0;
                    sda_oe_q <= 1'b0;
                  end else if (!sr[0]) begin
                    st <= ST_AHI;
                  end
                end
                ST_AHI: begin
                  addr_hi <= sr[HI_W-1:0];
                  st      <= ST_ALO;
                end
                ST_ALO: begin
                  cur_addr  <= word_addr;
                  row       <= word_addr[ADDR_W-1:PAGE_W];
                  woff      <= word_addr[PAGE_W-1:0];
                  have_data <= 1'b0;
                  pval      <= '0;
                  st        <= ST_WDAT;
                end
                default: begin
                  pval[woff] <= 1'b1;
                  woff       <= woff + PAGE_W'(1);
                  cur_addr   <= {row, woff + PAGE_W'(1)};
                  have_data  <= 1'b1;
                end
              endcase
            end else if (scl_fall && ack_ph) begin
              ack_ph   <= 1'b0;
              bitcnt   <= 4'd0;
              sda_oe_q <= 1'b0;
              if (st == ST_DEV) begin
                st       <= ST_RDAT;
                txsr     <= rdata;
                sda_oe_q <= ~rdata[7];
                cur_addr <= cur_addr + ADDR_W'(1);
              end
            end
          end
          ST_RDAT: begin
            if (!ack_ph) begin
              if (scl_rise && bitcnt < 4'd8) begin
                bitcnt <= bitcnt + 4'd1;
              end else if (scl_fall && bitcnt == 4'd8) begin
                sda_oe_q <= 1'b0;
                ack_ph   <= 1'b1;
              end else if (scl_fall && bitcnt != 4'd0) begin
                sda_oe_q <= ~txsr[6];
                txsr     <= {txsr[6:0], 1'b0};
              end
            end else begin
              if (scl_rise) begin
                m_ack <= ~sda_lvl;
              end else if (scl_fall) begin
                ack_ph <= 1'b0;
                bitcnt <= 4'd0;
                if (m_ack) begin
                  txsr     <= rdata;
                  sda_oe_q <= ~rdata[7];
                  cur_addr <= cur_addr + ADDR_W'(1);
                end else begin
                  st <= ST_IDLE;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = sda_oe_q;

  // R2
  ack_in_ninth_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_RDAT && !ack_ph) |-> !sda_oe_q);

  // R6
  quiet_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BUSY) |-> !sda_oe_q);

  // R9
  no_commit_protect_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tmr_busy) |-> !$past(wp_i, 2));
endmodule

// File: tb/tw_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module tw_eeprom_slave_tb_top;
  localparam int Q    = 6;
  localparam int WAIT = 600;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       wp = 1'b0;
  logic [2:0] sel = 3'b101;
  logic       sda_oe;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_val [$];
  string      exp_tag [$];
  logic [7:0] obs_val [$];

  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  tw_eeprom_slave #(.ADDR_W(10), .PAGE_W(4), .WR_CYCLES(400)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel_i(sel), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor: pairs each received byte with the next expected one
  always @(negedge clk) begin
    if (obs_val.size() != 0 && exp_val.size() != 0) begin
      logic [7:0] o, e;
      string t;
      o = obs_val.pop_front();
      e = exp_val.pop_front();
      t = exp_tag.pop_front();
      check(o == e, t, o, e);
    end
  end

  task automatic expect_byte(input string tag, input logic [7:0] v);
    exp_val.push_back(v);
    exp_tag.push_back(tag);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = (sda_line == 1'b0);
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_chk(input logic [7:0] v, input bit want, input string tag);
    bit a;
    send_byte(v, a);
    check(a == want, tag, a, want);
  endtask

  task automatic recv_byte(input bit mack);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      v[i] = sda_line;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    obs_val.push_back(v);
    sda_m = ~mack; tick(Q);
    scl_m = 1'b1;  tick(2 * Q);
    scl_m = 1'b0;  tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr_addr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    bus_start();
    send_chk(DEV_W, 1'b1, tag);
    send_chk(hi, 1'b1, tag);
    send_chk(lo, 1'b1, tag);
  endtask

  task automatic wr_byte(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d,
                         input string tag);
    wr_addr(hi, lo, tag);
    send_chk(d, 1'b1, tag);
    bus_stop();
    tick(WAIT);
  endtask

  task automatic rnd_read_setup(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    wr_addr(hi, lo, tag);
    bus_start();
    send_chk(DEV_R, 1'b1, tag);
  endtask

  task automatic poll(input bit want, input string tag);
    bus_start();
    send_chk(DEV_W, want, tag);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(10);
    // R1 reset state
    check(sda_oe == 1'b0, "R1 reset", sda_oe, 0);

    // R2 wrong select, wrong prefix, then no ack until a new start
    bus_start();
    send_chk(8'hA6, 1'b0, "R2 wrong select");
    bus_start();
    send_chk(8'hBA, 1'b0, "R2 wrong prefix");
    send_chk(DEV_W, 1'b0, "R2 ignored after mismatch");
    bus_stop();

    // R3 byte write at 0x123, R6 busy window
    wr_addr(8'h01, 8'h23, "R3 addr");
    send_chk(8'h5C, 1'b1, "R3 data");
    bus_stop();
    poll(1'b0, "R6 poll inside window");
    tick(WAIT);
    poll(1'b1, "R6 poll after window");

    // R5 random read, R3 upper address bits ignored (0x4123 -> 0x123)
    rnd_read_setup(8'h41, 8'h23, "R5 setup");
    expect_byte("R5 random read", 8'h5C);
    recv_byte(1'b0);
    tick(Q);
    // R1 line released after a declined read byte
    check(sda_oe == 1'b0, "R1 release after nack", sda_oe, 0);
    bus_stop();

    // R4 page write of 18 bytes from offset 14 of page 0x030
    wr_addr(8'h00, 8'h3E, "R4 addr");
    for (int i = 0; i < 18; i++) send_chk(8'h40 + 8'(i), 1'b1, "R4 data");
    bus_stop();
    tick(WAIT);

    // R8 current address after page write is offset 0 of the page
    bus_start();
    send_chk(DEV_R, 1'b1, "R8 dev");
    expect_byte("R8 current address", 8'h42);
    recv_byte(1'b0);
    bus_stop();

    // R7 sequential read inside the page
    rnd_read_setup(8'h00, 8'h3C, "R7 setup");
    expect_byte("R7 seq 0", 8'h4E);
    recv_byte(1'b1);
    expect_byte("R7 seq 1", 8'h4F);
    recv_byte(1'b1);
    expect_byte("R7 seq 2", 8'h50);
    recv_byte(1'b1);
    expect_byte("R7 seq 3", 8'h51);
    recv_byte(1'b0);
    bus_stop();

    // R7 wrap from the top of the array to 0
    wr_byte(8'h03, 8'hFF, 8'h99, "R7 top write");
    wr_byte(8'h00, 8'h00, 8'h77, "R7 bottom write");
    rnd_read_setup(8'h03, 8'hFF, "R7 wrap setup");
    expect_byte("R7 top", 8'h99);
    recv_byte(1'b1);
    expect_byte("R7 wrap to 0", 8'h77);
    recv_byte(1'b0);
    bus_stop();

    // R9 write protect: data acked, no window, array unchanged
    wp = 1'b1;
    wr_addr(8'h01, 8'h23, "R9 addr");
    send_chk(8'hEE, 1'b1, "R9 data ack");
    bus_stop();
    poll(1'b1, "R9 no busy window");
    wp = 1'b0;
    rnd_read_setup(8'h01, 8'h23, "R9 setup");
    expect_byte("R9 unchanged", 8'h5C);
    recv_byte(1'b0);
    bus_stop();

    // R10 stop in mid byte
    wr_addr(8'h01, 8'h23, "R10 addr");
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    poll(1'b1, "R10 no window after mid-byte stop");

    // R10 start in mid byte, device word acked right after
    wr_addr(8'h01, 8'h23, "R10 addr b");
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_start();
    send_chk(DEV_W, 1'b1, "R10 dev after mid-byte start");
    send_chk(8'h01, 1'b1, "R10 hi");
    send_chk(8'h23, 1'b1, "R10 lo");
    bus_start();
    send_chk(DEV_R, 1'b1, "R10 read dev");
    expect_byte("R10 unchanged after abandon", 8'h5C);
    recv_byte(1'b0);
    bus_stop();

    // R10 repeated start after a data byte discards it
    wr_addr(8'h01, 8'h23, "R10 addr c");
    send_chk(8'h66, 1'b1, "R10 data");
    bus_start();
    send_chk(DEV_W, 1'b1, "R10 dev after restart");
    bus_stop();
    poll(1'b1, "R10 no window after restart");
    rnd_read_setup(8'h01, 8'h23, "R10 setup d");
    expect_byte("R10 restart discards data", 8'h5C);
    recv_byte(1'b0);
    bus_stop();

    // R11 address-only write starts no window
    wr_addr(8'h00, 8'h50, "R11 addr");
    bus_stop();
    poll(1'b1, "R11 no window");

    tick(20);
    check(exp_val.size() == 0, "R7 scoreboard drained", exp_val.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule